// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block interprets the write cycles that a host issues to a parallel NOR flash whose command set is guarded by a two-write unlock handshake. Each write carries a byte address and a data word. The block turns these writes into an internal state. From that state it drives a read-mode select, which tells the read path whether to return array data, identification words, query table bytes or engine status. It also issues single-cycle requests to a separate program/erase engine: program a word, erase the whole chip, erase one sector, suspend a sector erase and resume it.

The storage, the query table contents and all erase timing live outside this block. The engine reports the end of an erase on `eraseDone`. For a program cycle, the array supplies the current word on `oldData`. The block then emits the word to store as the AND of old and new data, so a program can only clear bits. The block also supports a fast-program bypass, in which no unlock pair is needed. It provides a context-dependent reset command and a small identification-word multiplexer for autoselect reads.

Top module: `flash_cmd_seq`

## Requirements
- R1: A synchronous reset sets `readMode` to 0 (array), sets all strobes low and turns bypass off. After reset, a bare 0xA0 write followed by a data write issues no program.
- R2: The word address is the byte address shifted right by log2(BUS_BYTES). Only the low 11 bits of the word address are compared against `unlockAddr0` and `unlockAddr1`. A word address 0x800 above an unlock address therefore still matches it.
- R3: An unlock requires 0xAA at `unlockAddr0` and then 0x55 at `unlockAddr1`. Any other first or second write returns the block to array mode.
- R4: The third write must hit `unlockAddr0` unless bypass is on. Its low data byte selects the command: 0x90 sets autoselect (`readMode`=1), 0xA0 sets program-pending (`readMode`=3), 0x80 sets erase setup, and 0x20 turns bypass on. Any other value, or a miss on the address, returns to array mode.
- R5: While a program is pending, the next write raises `progStrobe` one cycle later, with `progAddr` equal to the write address and `progData` equal to the written data ANDed with `oldData`. The block then returns to array mode, or to the command state when bypass is on.
- R6: After 0x80, a second unlock pair followed by 0x10 at `unlockAddr0` raises `chipEraseStrobe` and sets `readMode`=3. 0x10 at any other address returns to array mode. A pulse on `eraseDone` ends the erase.
- R7: After 0x80 and a second unlock pair, 0x30 at any address raises `sectorEraseStrobe`, with `eraseAddr` equal to that byte address, and sets `readMode`=3.
- R8: In bypass mode, 0xA0 followed by a data write programs a word with no unlock pair, and this repeats. 0x90 under bypass enters autoselect, and writing 0x00 there leaves both autoselect and bypass.
- R9: A write of 0x98 at word address 0x55 from array mode sets `readMode`=2. Doing the same from autoselect also sets `readMode`=2, but a later 0xF0 returns to autoselect (`readMode`=1) instead of to array mode. Any other write in query mode returns to array mode.
- R10: 0xF0 returns to array mode and clears bypass, except in three cases. While a program is pending, 0xF0 is taken as program data. While an erase runs, 0xF0 is ignored and `readMode` stays 3. In nested query mode, 0xF0 returns to autoselect as R9 describes.
- R11: `idData` by word offset `idOffset` returns ID0 at 0x00, ID1 at 0x01, zero at 0x02, ID2 at 0x0E and ID3 at 0x0F, with `idValid` high. At all other offsets `idValid` is low.
- R12: 0xB0 in array mode has no effect. 0xB0 during a sector erase raises `suspendStrobe` and sets array mode. 0xB0 during a chip erase is ignored. While a sector erase is suspended, 0x30 raises `resumeStrobe` and sets `readMode`=3; with no erase suspended, 0x30 resets to array mode. A new erase command while an erase is suspended resets instead of erasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Bus write strobe, sampled on the rising edge |
| wrAddr | input | ADDR_W | Byte address of the write |
| wrData | input | DATA_W | Write data; the low byte is the command |
| unlockAddr0 | input | 11 | First unlock word address |
| unlockAddr1 | input | 11 | Second unlock word address |
| oldData | input | DATA_W | Current array word at `wrAddr` |
| eraseDone | input | 1 | Engine reports the running erase finished |
| idOffset | input | 8 | Word offset of an autoselect read |
| readMode | output | 2 | 0 array, 1 autoselect, 2 query, 3 status |
| idData | output | DATA_W | Identification word for `idOffset` |
| idValid | output | 1 | `idOffset` selects an identification word |
| progStrobe | output | 1 | One-cycle program request |
| progAddr | output | ADDR_W | Byte address to program |
| progData | output | DATA_W | Word to store (new AND old) |
| chipEraseStrobe | output | 1 | One-cycle chip erase request |
| sectorEraseStrobe | output | 1 | One-cycle sector erase request |
| eraseAddr | output | ADDR_W | Byte address inside the sector to erase |
| suspendStrobe | output | 1 | One-cycle erase suspend request |
| resumeStrobe | output | 1 | One-cycle erase resume request |

## Verification
A wrong internal state shows up at the ports only when a later write is interpreted. It appears either on `readMode`, one cycle after the write that should have moved it, or as a missing or extra strobe one cycle after the next data or command write. Bypass and suspension are never exposed directly. Each scenario therefore ends with a follow-up write whose outcome differs with that hidden bit, such as a bare 0xA0 that either raises `readMode` to 3 or leaves it at 0. This keeps the delay between a wrong state and its first visible symptom to at most two writes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int unsigned UNLOCK_W = 11;
  localparam int unsigned ID_OFF_W = 8;

  localparam logic [UNLOCK_W-1:0] QUERY_WORD = 11'h055;

  localparam logic [7:0] OP_UNLOCK_A   = 8'hAA;
  localparam logic [7:0] OP_UNLOCK_B   = 8'h55;
  localparam logic [7:0] OP_ERASE_SET  = 8'h80;
  localparam logic [7:0] OP_AUTOSEL    = 8'h90;
  localparam logic [7:0] OP_PROGRAM    = 8'hA0;
  localparam logic [7:0] OP_BYPASS     = 8'h20;
  localparam logic [7:0] OP_CHIP_ERASE = 8'h10;
  localparam logic [7:0] OP_SECT_ERASE = 8'h30;
  localparam logic [7:0] OP_SUSPEND    = 8'hB0;
  localparam logic [7:0] OP_QUERY      = 8'h98;
  localparam logic [7:0] OP_RESET      = 8'hF0;

  localparam logic [1:0] MODE_ARRAY   = 2'd0;
  localparam logic [1:0] MODE_AUTOSEL = 2'd1;
  localparam logic [1:0] MODE_QUERY   = 2'd2;
  localparam logic [1:0] MODE_STATUS  = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNL1,
    ST_CMD,
    ST_PROG,
    ST_EUNL0,
    ST_EUNL1,
    ST_ECMD,
    ST_ERASING,
    ST_AUTOSEL,
    ST_QUERY,
    ST_QUERY_NEST
  } seq_state_e;

  typedef struct packed {
    logic prog;
    logic chipErase;
    logic sectErase;
    logic suspend;
    logic resume;
  } seq_stb_t;

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic [7:0] cmd,
  input  logic       hitU0,
  input  logic       hitU1,
  input  logic       hitQuery,
  input  logic       eraseDone,
  output logic [1:0] readMode,
  output seq_stb_t   stbNext
);

  seq_state_e state, stateNext;
  logic bypass, bypassNext;
  logic suspended, suspendedNext;
  logic chipKind, chipKindNext;
  logic doReset;

  always_comb begin
    stateNext     = state;
    bypassNext    = bypass;
    suspendedNext = suspended;
    chipKindNext  = chipKind;
    stbNext       = '0;
    doReset       = 1'b0;

    if (state == ST_ERASING && eraseDone) begin
      stateNext = bypass ? ST_CMD : ST_IDLE;
    end else if (wrEn) begin
      if (cmd == OP_RESET && state != ST_PROG && state != ST_ERASING) begin
        if (state == ST_QUERY_NEST) stateNext = ST_AUTOSEL;
        else                        doReset   = 1'b1;
      end else begin
        unique case (state)
          ST_IDLE, ST_EUNL0: begin
            if (hitQuery && cmd == OP_QUERY) begin
              stateNext = ST_QUERY;
            end else if (cmd == OP_SECT_ERASE) begin
              if (suspended) begin
                stateNext     = ST_ERASING;
                chipKindNext  = 1'b0;
                suspendedNext = 1'b0;
                stbNext.resume = 1'b1;
              end else begin
                doReset = 1'b1;
              end
            end else if (cmd == OP_SUSPEND) begin
              stateNext = state;
            end else if (hitU0 && cmd == OP_UNLOCK_A) begin
              stateNext = (state == ST_IDLE) ? ST_UNL1 : ST_EUNL1;
            end else begin
              doReset = 1'b1;
            end
          end
          ST_UNL1, ST_EUNL1: begin
            if (hitU1 && cmd == OP_UNLOCK_B)
              stateNext = (state == ST_UNL1) ? ST_CMD : ST_ECMD;
            else
              doReset = 1'b1;
          end
          ST_CMD: begin
            if (!bypass && !hitU0) begin
              doReset = 1'b1;
            end else begin
              unique case (cmd)
                OP_BYPASS:    bypassNext = 1'b1;
                OP_ERASE_SET: stateNext  = ST_EUNL0;
                OP_AUTOSEL:   stateNext  = ST_AUTOSEL;
                OP_PROGRAM:   stateNext  = ST_PROG;
                default:      doReset    = 1'b1;
              endcase
            end
          end
          ST_PROG: begin
            stbNext.prog = 1'b1;
            stateNext    = bypass ? ST_CMD : ST_IDLE;
          end
          ST_AUTOSEL: begin
            if (hitQuery && cmd == OP_QUERY) stateNext = ST_QUERY_NEST;
            else                              doReset   = 1'b1;
          end
          ST_ECMD: begin
            if (suspended) begin
              doReset = 1'b1;
            end else if (cmd == OP_CHIP_ERASE && hitU0) begin
              stateNext         = ST_ERASING;
              chipKindNext      = 1'b1;
              stbNext.chipErase = 1'b1;
            end else if (cmd == OP_SECT_ERASE) begin
              stateNext         = ST_ERASING;
              chipKindNext      = 1'b0;
              stbNext.sectErase = 1'b1;
            end else begin
              doReset = 1'b1;
            end
          end
          ST_ERASING: begin
            if (!chipKind && cmd == OP_SUSPEND) begin
              stateNext       = ST_IDLE;
              suspendedNext   = 1'b1;
              stbNext.suspend = 1'b1;
            end
          end
          default: doReset = 1'b1;
        endcase
      end
    end

    if (doReset) begin
      stateNext  = ST_IDLE;
      bypassNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bypass    <= 1'b0;
      suspended <= 1'b0;
      chipKind  <= 1'b0;
    end else begin
      state     <= stateNext;
      bypass    <= bypassNext;
      suspended <= suspendedNext;
      chipKind  <= chipKindNext;
    end
  end

  always_comb begin
    unique case (state)
      ST_AUTOSEL:              readMode = MODE_AUTOSEL;
      ST_QUERY, ST_QUERY_NEST: readMode = MODE_QUERY;
      ST_PROG, ST_ERASING:     readMode = MODE_STATUS;
      default:                 readMode = MODE_ARRAY;
    endcase
  end

endmodule

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int unsigned BUS_BYTES = 2,
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 16,
  parameter logic [DATA_W-1:0] ID0 = 16'h0001,
  parameter logic [DATA_W-1:0] ID1 = 16'h227E,
  parameter logic [DATA_W-1:0] ID2 = 16'h2221,
  parameter logic [DATA_W-1:0] ID3 = 16'h2201
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [UNLOCK_W-1:0] unlockAddr0,
  input  logic [UNLOCK_W-1:0] unlockAddr1,
  input  logic [DATA_W-1:0]   oldData,
  input  logic [ID_OFF_W-1:0] idOffset,
  input  seq_stb_t            stbNext,
  output logic [7:0]          cmd,
  output logic                hitU0,
  output logic                hitU1,
  output logic                hitQuery,
  output logic [DATA_W-1:0]   idData,
  output logic                idValid,
  output logic                progStrobe,
  output logic [ADDR_W-1:0]   progAddr,
  output logic [DATA_W-1:0]   progData,
  output logic                chipEraseStrobe,
  output logic                sectorEraseStrobe,
  output logic [ADDR_W-1:0]   eraseAddr,
  output logic                suspendStrobe,
  output logic                resumeStrobe
);

  localparam int unsigned SHIFT = (BUS_BYTES == 4) ? 2 : (BUS_BYTES == 2) ? 1 : 0;

  logic [UNLOCK_W-1:0] wordLow;

  generate
    if (SHIFT == 0) begin : g_bus8
      assign wordLow = wrAddr[UNLOCK_W-1:0];
    end else begin : g_busWide
      assign wordLow = wrAddr[SHIFT +: UNLOCK_W];
    end
  endgenerate

  assign cmd      = wrData[7:0];
  assign hitU0    = (wordLow == unlockAddr0);
  assign hitU1    = (wordLow == unlockAddr1);
  assign hitQuery = (wordLow == QUERY_WORD);

  always_comb begin
    idValid = 1'b1;
    unique case (idOffset)
      8'h00:   idData = ID0;
      8'h01:   idData = ID1;
      8'h02:   idData = '0;
      8'h0E:   idData = ID2;
      8'h0F:   idData = ID3;
      default: begin
        idData  = '0;
        idValid = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      progStrobe        <= 1'b0;
      chipEraseStrobe   <= 1'b0;
      sectorEraseStrobe <= 1'b0;
      suspendStrobe     <= 1'b0;
      resumeStrobe      <= 1'b0;
      progAddr          <= '0;
      progData          <= '0;
      eraseAddr         <= '0;
    end else begin
      progStrobe        <= stbNext.prog;
      chipEraseStrobe   <= stbNext.chipErase;
      sectorEraseStrobe <= stbNext.sectErase;
      suspendStrobe     <= stbNext.suspend;
      resumeStrobe      <= stbNext.resume;
      if (stbNext.prog) begin
        progAddr <= wrAddr;
        progData <= wrData & oldData;
      end
      if (stbNext.chipErase || stbNext.sectErase) eraseAddr <= wrAddr;
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned BUS_BYTES = 2,
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 16,
  parameter logic [DATA_W-1:0] ID0 = 16'h0001,
  parameter logic [DATA_W-1:0] ID1 = 16'h227E,
  parameter logic [DATA_W-1:0] ID2 = 16'h2221,
  parameter logic [DATA_W-1:0] ID3 = 16'h2201
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [10:0]       unlockAddr0,
  input  logic [10:0]       unlockAddr1,
  input  logic [DATA_W-1:0] oldData,
  input  logic              eraseDone,
  input  logic [7:0]        idOffset,
  output logic [1:0]        readMode,
  output logic [DATA_W-1:0] idData,
  output logic              idValid,
  output logic              progStrobe,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData,
  output logic              chipEraseStrobe,
  output logic              sectorEraseStrobe,
  output logic [ADDR_W-1:0] eraseAddr,
  output logic              suspendStrobe,
  output logic              resumeStrobe
);

  seq_stb_t   stbNext;
  logic [7:0] cmd;
  logic       hitU0, hitU1, hitQuery;

  flash_seq_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .cmd       (cmd),
    .hitU0     (hitU0),
    .hitU1     (hitU1),
    .hitQuery  (hitQuery),
    .eraseDone (eraseDone),
    .readMode  (readMode),
    .stbNext   (stbNext)
  );

  flash_seq_dp #(
    .BUS_BYTES (BUS_BYTES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ID0       (ID0),
    .ID1       (ID1),
    .ID2       (ID2),
    .ID3       (ID3)
  ) i_dp (
    .clk               (clk),
    .rst               (rst),
    .wrAddr            (wrAddr),
    .wrData            (wrData),
    .unlockAddr0       (unlockAddr0),
    .unlockAddr1       (unlockAddr1),
    .oldData           (oldData),
    .idOffset          (idOffset),
    .stbNext           (stbNext),
    .cmd               (cmd),
    .hitU0             (hitU0),
    .hitU1             (hitU1),
    .hitQuery          (hitQuery),
    .idData            (idData),
    .idValid           (idValid),
    .progStrobe        (progStrobe),
    .progAddr          (progAddr),
    .progData          (progData),
    .chipEraseStrobe   (chipEraseStrobe),
    .sectorEraseStrobe (sectorEraseStrobe),
    .eraseAddr         (eraseAddr),
    .suspendStrobe     (suspendStrobe),
    .resumeStrobe      (resumeStrobe)
  );

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] oldData,
  input logic [1:0]        readMode,
  input logic              progStrobe,
  input logic [DATA_W-1:0] progData,
  input logic              chipEraseStrobe,
  input logic              sectorEraseStrobe,
  input logic              suspendStrobe,
  input logic              resumeStrobe
);

  logic [4:0] allStb;
  assign allStb = {progStrobe, chipEraseStrobe, sectorEraseStrobe, suspendStrobe, resumeStrobe};

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (readMode == 2'd0 && allStb == 5'd0));

  assert_one_request_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(allStb));

  assert_prog_clears_only_R5: assert property (@(posedge clk) disable iff (rst)
    progStrobe |-> ((progData | $past(oldData)) == $past(oldData)));

  assert_prog_after_pending_R5: assert property (@(posedge clk) disable iff (rst)
    progStrobe |-> ($past(readMode) == 2'd3 && $past(wrEn)));

  assert_erase_status_R6: assert property (@(posedge clk) disable iff (rst)
    (chipEraseStrobe || sectorEraseStrobe || resumeStrobe) |-> readMode == 2'd3);

  assert_query_entry_R9: assert property (@(posedge clk) disable iff (rst)
    (readMode == 2'd2 && $past(readMode) != 2'd2) |-> ($past(wrEn) && $past(wrData[7:0]) == 8'h98));

  assert_suspend_array_R12: assert property (@(posedge clk) disable iff (rst)
    suspendStrobe |-> (readMode == 2'd0 && $past(readMode) == 2'd3));

endmodule

bind flash_cmd_seq flash_seq_chk #(.DATA_W(DATA_W)) i_chk (
  .clk               (clk),
  .rst               (rst),
  .wrEn              (wrEn),
  .wrData            (wrData),
  .oldData           (oldData),
  .readMode          (readMode),
  .progStrobe        (progStrobe),
  .progData          (progData),
  .chipEraseStrobe   (chipEraseStrobe),
  .sectorEraseStrobe (sectorEraseStrobe),
  .suspendStrobe     (suspendStrobe),
  .resumeStrobe      (resumeStrobe)
);

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;

  localparam int unsigned ADDR_W = 20;
  localparam int unsigned DATA_W = 16;
  localparam logic [ADDR_W-1:0] A_U0 = 20'h00AAA;  // word 0x555
  localparam logic [ADDR_W-1:0] A_U1 = 20'h00554;  // word 0x2AA
  localparam logic [ADDR_W-1:0] A_Q  = 20'h000AA;  // word 0x055

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] oldData = 16'hFFFF;
  logic eraseDone = 1'b0;
  logic [7:0] idOffset = '0;
  logic [1:0] readMode;
  logic [DATA_W-1:0] idData, progData;
  logic idValid, progStrobe, chipEraseStrobe, sectorEraseStrobe, suspendStrobe, resumeStrobe;
  logic [ADDR_W-1:0] progAddr, eraseAddr;

  int nChecks = 0;
  int nFails = 0;

  logic [1:0] sMode;
  logic [4:0] sStb;
  logic [ADDR_W-1:0] sPA, sEA;
  logic [DATA_W-1:0] sPD;

  always #2 clk = ~clk;

  flash_cmd_seq i_flash_cmd_seq (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .unlockAddr0(11'h555), .unlockAddr1(11'h2AA), .oldData(oldData),
    .eraseDone(eraseDone), .idOffset(idOffset), .readMode(readMode),
    .idData(idData), .idValid(idValid), .progStrobe(progStrobe),
    .progAddr(progAddr), .progData(progData), .chipEraseStrobe(chipEraseStrobe),
    .sectorEraseStrobe(sectorEraseStrobe), .eraseAddr(eraseAddr),
    .suspendStrobe(suspendStrobe), .resumeStrobe(resumeStrobe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sample();
    @(posedge clk);
    #1;
    sMode = readMode;
    sStb  = {progStrobe, chipEraseStrobe, sectorEraseStrobe, suspendStrobe, resumeStrobe};
    sPA = progAddr; sPD = progData; sEA = eraseAddr;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    sample();
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic done();
    @(negedge clk);
    eraseDone = 1'b1;
    sample();
    @(negedge clk);
    eraseDone = 1'b0;
  endtask

  task automatic unlock(input logic [ADDR_W-1:0] u0 = A_U0);
    wr(u0, 16'h00AA);
    wr(A_U1, 16'h0055);
  endtask

  // stb bits: {prog, chip, sect, susp, resume}
  task automatic t_reset();
    chk("R1 mode after reset", readMode, 2'd0);
    chk("R1 strobes after reset", {progStrobe, chipEraseStrobe, sectorEraseStrobe, suspendStrobe, resumeStrobe}, 5'd0);
    wr(20'h00010, 16'h00A0);
    chk("R1 bare A0 no pending", sMode, 2'd0);
    wr(20'h00010, 16'h1234);
    chk("R1 no program after reset", sStb, 5'd0);
  endtask

  task automatic t_program();
    unlock();
    wr(A_U0, 16'h00A0);
    chk("R4 program pending status", sMode, 2'd3);
    oldData = 16'h3C3C;
    wr(20'h12340, 16'hF0F0);
    chk("R5 prog strobe", sStb, 5'b10000);
    chk("R5 prog data AND", sPD, 16'h3030);
    chk("R5 prog addr", sPA, 20'h12340);
    chk("R5 back to array", sMode, 2'd0);
    unlock();
    wr(A_U0, 16'h00A0);
    oldData = 16'hFFFF;
    wr(20'h00100, 16'h00F0);
    chk("R10 F0 as program data", sStb, 5'b10000);
    chk("R10 F0 data value", sPD, 16'h00F0);
  endtask

  task automatic t_bad_unlock();
    wr(A_U0, 16'h00AA);
    wr(20'h00556, 16'h0055);
    wr(A_U0, 16'h00A0);
    chk("R3 wrong second address", sMode, 2'd0);
    wr(A_U0, 16'h00AB);
    wr(A_U1, 16'h0055);
    wr(A_U0, 16'h00A0);
    chk("R3 wrong first data", sMode, 2'd0);
    unlock();
    wr(A_U0, 16'h0077);
    chk("R4 unknown command", sMode, 2'd0);
    wr(A_U0, 16'h00A0);
    chk("R4 unknown command resets", sMode, 2'd0);
    unlock();
    wr(A_U1, 16'h00A0);
    chk("R4 command off unlock address", sMode, 2'd0);
  endtask

  task automatic t_alias();
    unlock(20'h01AAA);           // word 0xD55, low 11 bits 0x555
    wr(20'h01AAA, 16'h0090);
    chk("R2 11-bit alias of unlock address", sMode, 2'd1);
    wr(20'h00000, 16'h00F0);
    unlock(20'h00555);           // unshifted byte address: word 0x2AA
    wr(A_U0, 16'h0090);
    chk("R2 byte address not word address", sMode, 2'd0);
  endtask

  task automatic t_autosel();
    unlock();
    wr(A_U0, 16'h0090);
    chk("R4 autoselect mode", sMode, 2'd1);
    idOffset = 8'h00; #1; chk("R11 ID0", {idValid, idData}, {1'b1, 16'h0001});
    idOffset = 8'h01; #1; chk("R11 ID1", {idValid, idData}, {1'b1, 16'h227E});
    idOffset = 8'h02; #1; chk("R11 protect word", {idValid, idData}, {1'b1, 16'h0000});
    idOffset = 8'h0E; #1; chk("R11 ID2", {idValid, idData}, {1'b1, 16'h2221});
    idOffset = 8'h0F; #1; chk("R11 ID3", {idValid, idData}, {1'b1, 16'h2201});
    idOffset = 8'h05; #1; chk("R11 other offset", idValid, 1'b0);
    wr(20'h00000, 16'h00F0);
    chk("R10 F0 leaves autoselect", sMode, 2'd0);
  endtask

  task automatic t_query();
    wr(A_Q, 16'h0098);
    chk("R9 query entry", sMode, 2'd2);
    wr(20'h00000, 16'h00F0);
    chk("R9 F0 from query", sMode, 2'd0);
    wr(A_U0, 16'h0098);
    chk("R9 query wrong address", sMode, 2'd0);
    unlock();
    wr(A_U0, 16'h0090);
    wr(A_Q, 16'h0098);
    chk("R9 nested query entry", sMode, 2'd2);
    wr(20'h00000, 16'h00F0);
    chk("R9 F0 back to autoselect", sMode, 2'd1);
    wr(A_Q, 16'h0098);
    wr(20'h00000, 16'h0012);
    chk("R9 other write leaves query", sMode, 2'd0);
  endtask

  task automatic t_chip();
    unlock(); wr(A_U0, 16'h0080); unlock();
    wr(A_U1, 16'h0010);
    chk("R6 chip erase off address", {sMode, sStb}, {2'd0, 5'd0});
    unlock(); wr(A_U0, 16'h0080); unlock();
    wr(A_U0, 16'h0010);
    chk("R6 chip erase strobe", sStb, 5'b01000);
    chk("R6 chip erase status", sMode, 2'd3);
    wr(20'h00000, 16'h00F0);
    chk("R10 F0 ignored in erase", sMode, 2'd3);
    wr(20'h00000, 16'h00B0);
    chk("R12 no suspend of chip erase", {sMode, sStb}, {2'd3, 5'd0});
    done();
    chk("R6 erase done", sMode, 2'd0);
  endtask

  task automatic t_sector();
    wr(20'h00000, 16'h00B0);
    chk("R12 B0 in array mode", {sMode, sStb}, {2'd0, 5'd0});
    wr(20'h00000, 16'h0030);
    chk("R12 resume without suspend", {sMode, sStb}, {2'd0, 5'd0});
    unlock(); wr(A_U0, 16'h0080); unlock();
    wr(20'h12346, 16'h0030);
    chk("R7 sector strobe", sStb, 5'b00100);
    chk("R7 sector addr", sEA, 20'h12346);
    chk("R7 sector status", sMode, 2'd3);
    wr(20'h00000, 16'h00B0);
    chk("R12 suspend strobe", {sMode, sStb}, {2'd0, 5'b00010});
    unlock(); wr(A_U0, 16'h0080); unlock();
    wr(20'h20000, 16'h0030);
    chk("R12 erase while suspended resets", {sMode, sStb}, {2'd0, 5'd0});
    wr(20'h00000, 16'h0030);
    chk("R12 resume strobe", {sMode, sStb}, {2'd3, 5'b00001});
    done();
    chk("R7 sector done", sMode, 2'd0);
  endtask

  task automatic t_bypass();
    unlock();
    wr(A_U0, 16'h0020);
    chk("R8 bypass entry mode", sMode, 2'd0);
    for (int k = 0; k < 2; k++) begin
      wr(20'h00300, 16'h00A0);
      chk("R8 bypass program pending", sMode, 2'd3);
      oldData = 16'hFF0F;
      wr(20'h00400 + 20'(k * 2), 16'h0FFF);
      chk("R8 bypass program strobe", sStb, 5'b10000);
      chk("R8 bypass program data", sPD, 16'h0F0F);
    end
    wr(20'h00000, 16'h0090);
    chk("R8 bypass autoselect", sMode, 2'd1);
    wr(20'h00000, 16'h0000);
    chk("R8 bypass exit", sMode, 2'd0);
    wr(20'h00300, 16'h00A0);
    chk("R8 bypass off after exit", sMode, 2'd0);
    unlock();
    wr(A_U0, 16'h0020);
    wr(20'h00000, 16'h00F0);
    wr(20'h00300, 16'h00A0);
    chk("R10 F0 clears bypass", sMode, 2'd0);
    oldData = 16'hFFFF;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_bad_unlock();
    t_alias();
    t_autosel();
    t_query();
    t_chip();
    t_sector();
    t_bypass();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule